// File: doc/BRIEF.md
# Programmable Bit-Clock Divider

This block turns a fast reference clock into a slower square-wave bit clock for serial transmit and receive logic. Software writes a 16-bit time constant as two byte-wide halves. A down counter loads from the constant and counts down to zero. Each time it reaches zero, the bit clock toggles and the counter loads the constant again. The block also gives a one-cycle strobe on every counted toggle, so synchronous logic in the reference domain can use it as a clock enable instead of using the square wave as a clock.

The sequencing is held in a three-state controller:
- `ST_IDLE`: disabled. The output is held high and the counter keeps its value.
- `ST_LOAD`: one cycle in which the counter copies the time constant.
- `ST_COUNT`: the counter decrements once per cycle until it is zero.

The transitions are:
- IDLE→LOAD when enabled.
- LOAD→COUNT while enabled.
- COUNT→COUNT while the count is non-zero.
- COUNT→LOAD on a zero count, which also toggles the output.
- Any state→IDLE as soon as the enable is low.

One half period is therefore the load cycle plus the cycles spent on counter values TC down to 0, which is TC + 2 reference clocks. This matches the usual sizing rule TC = f_ref / (2 · baud · mode) − 2, where mode is 1, 16, 32 or 64.

Top module: `baud_div`

## Requirements
- R1: `tc_wr_en[0]` writes `tc_wr_data` into bits 7:0 of the time constant, and `tc_wr_en[1]` writes it into bits 15:8. Each half is written without changing the other half.
- R2: After reset, `bit_clk` is 1, `tick_pulse` is 0 and the time constant is `TC_RESET` (default 0).
- R3: While `run_en` is low, `bit_clk` stays 1 and `tick_pulse` stays 0, from the cycle after `run_en` is first sampled low.
- R4: Call k the first rising edge that samples `run_en` high while idle. `bit_clk` is high until edge k+TC+1 and falls at edge k+TC+2.
- R5: While enabled, every half period of `bit_clk` after the first lasts exactly TC + 2 reference clocks.
- R6: A time constant written during a count does not alter the half period in progress. It is used from the next reload.
- R7: `tick_pulse` is high for exactly one cycle on each counted toggle, in the same cycle in which `bit_clk` shows its new level. There is exactly one pulse per half period.
- R8: The smallest constant, TC = 0, gives a half period of 2 clocks. Constants that use both halves, such as 0x0102 giving 260 clocks, are honoured in full.
- R9: Dropping `run_en` while `bit_clk` is low forces `bit_clk` high in the next cycle without a pulse. Enabling again restarts with a fresh load, with the R4 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock driving the divider |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enable; its rising level starts the divider |
| tc_wr_en | input | CNT_W/BYTE_W | Per-half write strobes, bit 0 for the low byte |
| tc_wr_data | input | BYTE_W | Byte written into the selected half |
| bit_clk | output | 1 | Square-wave bit clock, high when idle |
| tick_pulse | output | 1 | One-cycle strobe on each counted toggle |

## Verification
The bench builds the divider with the default parameters: a 16-bit constant split into two 8-bit halves, and a reset constant of 0. With a 16-bit constant, half periods from 2 up to a few hundred clocks stay short enough to measure edge by edge. This includes the minimum constant, which runs straight after reset, and constants that exercise the high half alone. The byte-wide halves let the bench write a single half and observe the combined value in the output timing. Mid-count rewrites and disables in both output phases are timed against the TC + 2 rule.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } div_state_e;

endpackage

// File: rtl/baud_div_tc_regs.sv
module baud_div_tc_regs #(
    parameter int CNT_W    = 16,
    parameter int BYTE_W   = 8,
    parameter int TC_RESET = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W/BYTE_W-1:0]   wr_en,
    input  logic [BYTE_W-1:0]         wr_data,
    output logic [CNT_W-1:0]          tc_value
);
    localparam int HALVES = CNT_W / BYTE_W;
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(TC_RESET);

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tc_value[g*BYTE_W +: BYTE_W] <= RST_VAL[g*BYTE_W +: BYTE_W];
            end else if (wr_en[g]) begin
                tc_value[g*BYTE_W +: BYTE_W] <= wr_data;
            end
        end

        // R1: a strobe on another half leaves this half untouched
        p_half_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(tc_value[g*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign cnt_zero = (cnt == '0);

    // R5: the counter never wraps below zero
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !cnt_zero);

endmodule

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl
    import baud_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       cnt_zero,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       bit_clk,
    output logic       tick_pulse,
    output div_state_e state
);
    div_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  state_d = run_en ? ST_LOAD : ST_IDLE;
            ST_LOAD:  state_d = run_en ? ST_COUNT : ST_IDLE;
            ST_COUNT: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end else if (cnt_zero) begin
                    state_d = ST_LOAD;
                end else begin
                    state_d = ST_COUNT;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // counter strobes
    always_comb begin
        cnt_load = (state == ST_LOAD) && run_en;
        cnt_dec  = (state == ST_COUNT) && run_en && !cnt_zero;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_clk    <= 1'b1;
            tick_pulse <= 1'b0;
        end else if (!run_en) begin
            bit_clk    <= 1'b1;
            tick_pulse <= 1'b0;
        end else begin
            tick_pulse <= 1'b0;
            unique case (state)
                ST_IDLE:  bit_clk <= 1'b1;
                ST_LOAD:  bit_clk <= bit_clk;
                ST_COUNT: begin
                    if (cnt_zero) begin
                        bit_clk    <= ~bit_clk;
                        tick_pulse <= 1'b1;
                    end
                end
                default:  bit_clk <= 1'b1;
            endcase
        end
    end

    // R3: disabled means high output and no strobe
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (bit_clk && !tick_pulse));

    // R7: every strobe coincides with a change of the output
    p_pulse_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |-> (bit_clk != $past(bit_clk)));

    // R7: strobes are never back to back
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

    // R5: a zero count while running is followed by a reload
    p_reload_after_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && cnt_zero && run_en) |=> (state == ST_LOAD));

endmodule

// File: rtl/baud_div.sv
module baud_div
    import baud_div_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BYTE_W   = 8,
    parameter int TC_RESET = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic [CNT_W/BYTE_W-1:0] tc_wr_en,
    input  logic [BYTE_W-1:0]       tc_wr_data,
    output logic                    bit_clk,
    output logic                    tick_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] tc_value;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             cnt_load;
    logic             cnt_dec;
    div_state_e       state;

    baud_div_tc_regs #(
        .CNT_W(CNT_W), .BYTE_W(BYTE_W), .TC_RESET(TC_RESET)
    ) u_tc (
        .clk(clk), .rst_n(rst_n), .wr_en(tc_wr_en),
        .wr_data(tc_wr_data), .tc_value(tc_value)
    );

    baud_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
        .load_val(tc_value), .cnt(cnt), .cnt_zero(cnt_zero)
    );

    baud_div_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_zero(cnt_zero),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .bit_clk(bit_clk),
        .tick_pulse(tick_pulse), .state(state)
    );

    // R4: the load cycle copies the constant held in the registers
    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && run_en) |=> (cnt == $past(tc_value)));

    // R6: a count in progress steps by one whatever is written meanwhile
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && run_en && !cnt_zero) |=> (cnt == $past(cnt) - ONE));

    // R3: the counter holds while idle
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(cnt));

endmodule

// File: tb/baud_div_bench.sv
module baud_div_bench;
    localparam int NV = 6;
    localparam logic [15:0] V_TC   [NV] = '{16'h0000, 16'h0001, 16'h0005,
                                           16'h00FF, 16'h0102, 16'h0013};
    localparam int          V_HALF [NV] = '{2, 3, 7, 257, 260, 21};
    localparam int LIMIT = 70000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] tc_wr_en = 2'b00;
    logic [7:0] tc_wr_data = 8'h00;
    logic       bit_clk;
    logic       tick_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    baud_div u_baud_div (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tc_wr_en(tc_wr_en),
        .tc_wr_data(tc_wr_data), .bit_clk(bit_clk), .tick_pulse(tick_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_half(input logic [1:0] sel, input logic [7:0] val);
        tc_wr_en = sel;
        tc_wr_data = val;
        @(negedge clk);
        tc_wr_en = 2'b00;
    endtask

    task automatic write_tc(input logic [15:0] val);
        write_half(2'b01, val[7:0]);
        write_half(2'b10, val[15:8]);
    endtask

    // count negedges until bit_clk reaches lvl; n starts from n_in
    task automatic run_until(input logic lvl, input int n_in, output int n, output int pulses);
        n = n_in;
        pulses = 0;
        do begin
            @(negedge clk);
            n++;
            pulses += int'(tick_pulse);
        end while (bit_clk != lvl && n < LIMIT);
    endtask

    task automatic go_idle(input string req);
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(bit_clk === 1'b1 && tick_pulse === 1'b0, req, int'(bit_clk), 1);
    endtask

    // enable from idle and time the first and second half periods
    task automatic measure(input int half, input string req);
        int n, p;
        run_en = 1'b1;
        run_until(1'b0, 0, n, p);
        check(n == half + 1, req, n, half + 1);
        check(p == 1 && tick_pulse === 1'b1, "R7", p, 1);
        run_until(1'b1, 0, n, p);
        check(n == half, "R5", n, half);
        check(p == 1, "R7", p, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, p;
        // R2 reset state
        repeat (3) @(negedge clk);
        check(bit_clk === 1'b1 && tick_pulse === 1'b0, "R2", int'(bit_clk), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(bit_clk === 1'b1 && tick_pulse === 1'b0, "R2", int'(bit_clk), 1);
        // R2/R8: reset constant 0 gives a half period of 2
        measure(2, "R2");

        // vector table walk (R4, R5, R8)
        for (int i = 0; i < NV; i++) begin
            go_idle("R3");
            write_tc(V_TC[i]);
            measure(V_HALF[i], (V_TC[i] == 16'h0102) ? "R8" : "R4");
        end

        // R1: write only the high half on top of 0x0005 -> 0x0105
        go_idle("R3");
        write_tc(16'h0005);
        write_half(2'b10, 8'h01);
        measure(263, "R1");
        // R1: write only the low half -> 0x0100
        go_idle("R3");
        write_half(2'b01, 8'h00);
        measure(258, "R1");

        // R6: rewrite in mid-count; current half keeps the old constant
        go_idle("R3");
        write_tc(16'd10);
        run_en = 1'b1;
        n = 0;
        repeat (5) begin
            @(negedge clk);
            n++;
        end
        tc_wr_en = 2'b01;
        tc_wr_data = 8'd3;
        @(negedge clk);
        n++;
        tc_wr_en = 2'b10;
        tc_wr_data = 8'd0;
        @(negedge clk);
        n++;
        tc_wr_en = 2'b00;
        run_until(1'b0, n, n, p);
        check(n == 13, "R6", n, 13);
        run_until(1'b1, 0, n, p);
        check(n == 5, "R6", n, 5);
        run_until(1'b0, 0, n, p);
        check(n == 5 && p == 1, "R6", n, 5);

        // R9: disable while low
        go_idle("R3");
        write_tc(16'd20);
        run_en = 1'b1;
        run_until(1'b0, 0, n, p);
        check(n == 23, "R4", n, 23);
        run_en = 1'b0;
        @(negedge clk);
        check(bit_clk === 1'b1, "R9", int'(bit_clk), 1);
        check(tick_pulse === 1'b0, "R9", int'(tick_pulse), 0);
        p = 0;
        n = 0;
        repeat (30) begin
            @(negedge clk);
            p += int'(tick_pulse);
            n += int'(!bit_clk);
        end
        check(p == 0 && n == 0, "R3", p + n, 0);
        measure(22, "R9");

        // R9: disable mid-count while high, then restart fresh
        go_idle("R3");
        run_en = 1'b1;
        repeat (10) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(bit_clk === 1'b1 && tick_pulse === 1'b0, "R9", int'(bit_clk), 1);
        measure(22, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule